// File: doc/BRIEF.md
# Drawing-Engine Command Queue with Status Word

This block sits between a host register port and a drawing engine. The host writes commands into a small first-in first-out queue. The block hands them to the engine one at a time over a valid/ready pair. A single 32-bit status word, readable at all times, tells the host how much room is left in the queue, whether either downstream stage is still working, and whether an error has been recorded since the host last cleared it.

Host software paces itself by reading the free-entry field before it writes. It treats the last eight reported entries as a safety margin and does not count on them. If a write arrives anyway when the queue has no room, the block discards the command and latches an overflow flag. A separate input records a failed host read in a second flag. Both flags hold until the host writes a one to that bit.

Top module: `cmd_queue_csr`

## Requirements
- R1: After reset the status word reads DEPTH in bits 11:0 and zero in every other bit, and `eng_valid` is low.
- R2: Bits 11:0 of `csr_rdata` always equal DEPTH minus the number of queued commands. The field drops by one in the cycle after an accepted write and rises by one in the cycle after a command is taken (`eng_valid` and `eng_ready` both high).
- R3: When a command is accepted and another is taken in the same cycle, the free-entry field is unchanged.
- R4: A command written while the free field is zero is discarded, even if a command is taken in that cycle. The queue contents do not change, and bit 31 (overflow) is set in the next cycle.
- R5: Commands leave on `eng_data` in the order they were accepted, and `eng_valid` is high exactly when the queue is non-empty.
- R6: Bit 24 (framebuffer busy) is high when the queue is non-empty or `fb_active` is high. Bit 25 (raster busy) is high when the queue is non-empty or `raster_active` is high.
- R7: A pulse on `rd_fault` sets bit 30 (read error) in the next cycle, and the bit stays set.
- R8: A status write with a one in bit 30 or bit 31 clears that flag. A zero in that position leaves the flag alone. If a flag is set and cleared in the same cycle, setting wins.
- R9: Bits 23:12 and 29:26 always read zero. A status write never changes the free field or the busy bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_wdata | input | DATA_W | Command word to queue |
| csr_wr | input | 1 | Host write strobe for the status word |
| csr_wdata | input | 32 | Status write data (ones in bits 31/30 clear flags) |
| csr_rdata | output | 32 | Status word |
| rd_fault | input | 1 | Pulse reporting a failed host read |
| raster_active | input | 1 | Raster stage reports activity |
| fb_active | input | 1 | Framebuffer stage reports activity |
| eng_valid | output | 1 | Command available to engine |
| eng_data | output | DATA_W | Head command |
| eng_ready | input | 1 | Engine takes the head command |

## Verification
The hardest state to reach is a queue that is exactly full while the engine is also draining. Two things must be true at once there: the excess write must be dropped and the overflow flag must latch, while the pop still goes through. The bench fills the queue past capacity with `eng_ready` held low, checking the free field after every write. It then holds a full queue with a write and a pop in the same cycle, and drains while checking order. A flag set and cleared in the same cycle is reached by pulsing `rd_fault` together with a clearing write.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int FREE_W   = 12;
  localparam int BIT_FBB  = 24;
  localparam int BIT_RPB  = 25;
  localparam int BIT_RDE  = 30;
  localparam int BIT_OVF  = 31;

  // Free entries from total depth and current occupancy.
  function automatic logic [FREE_W-1:0] cq_free(input int depth, input int used);
    return FREE_W'(depth - used);
  endfunction

  // Assemble the status word; unlisted bits are zero.
  function automatic logic [31:0] cq_pack(input logic [FREE_W-1:0] free_n,
                                          input logic fbb, input logic rpb,
                                          input logic rde, input logic ovf);
    logic [31:0] w;
    w = '0;
    w[FREE_W-1:0] = free_n;
    w[BIT_FBB] = fbb;
    w[BIT_RPB] = rpb;
    w[BIT_RDE] = rde;
    w[BIT_OVF] = ovf;
    return w;
  endfunction
endpackage

// File: rtl/cq_storage.sv
module cq_storage #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              head_valid,
  output logic [DATA_W-1:0] head_data,
  output logic [$clog2(DEPTH+1)-1:0] used,
  output logic              push_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic full, push_acc, pop_acc;

  assign full      = (cnt == CW'(DEPTH));
  assign push_acc  = push_req && !full;
  assign push_drop = push_req && full;
  assign pop_acc   = pop_req && (cnt != '0);

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_acc) wp <= wrap_inc(wp);
      if (pop_acc)  rp <= wrap_inc(rp);
      case ({push_acc, pop_acc})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wp] <= push_data;
  end

  assign head_valid = (cnt != '0);
  assign head_data  = mem[rp];
  assign used       = cnt;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_pushpop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> $stable(cnt));
  assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_req) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/cq_status.sv
module cq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovf,
  input  logic set_rde,
  input  logic wr_en,
  input  logic clr_ovf_bit,
  input  logic clr_rde_bit,
  output logic ovf_flag,
  output logic rde_flag
);
  logic clr_ovf, clr_rde;
  assign clr_ovf = wr_en && clr_ovf_bit;
  assign clr_rde = wr_en && clr_rde_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      rde_flag <= 1'b0;
    end else begin
      if (set_ovf)      ovf_flag <= 1'b1;
      else if (clr_ovf) ovf_flag <= 1'b0;
      if (set_rde)      rde_flag <= 1'b1;
      else if (clr_rde) rde_flag <= 1'b0;
    end
  end

  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> ovf_flag);
  assert_rde_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_rde |=> rde_flag);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);
  assert_rde_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rde && !set_rde) |=> !rde_flag);
endmodule

// File: rtl/cmd_queue_csr.sv
module cmd_queue_csr #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              csr_wr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              rd_fault,
  input  logic              raster_active,
  input  logic              fb_active,
  output logic              eng_valid,
  output logic [DATA_W-1:0] eng_data,
  input  logic              eng_ready
);
  import cq_pkg::*;
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] used;
  logic push_drop, ovf_flag, rde_flag, fb_busy, rp_busy;

  cq_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_req(cmd_wr), .push_data(cmd_wdata),
    .pop_req(eng_ready),
    .head_valid(eng_valid), .head_data(eng_data),
    .used(used), .push_drop(push_drop)
  );

  cq_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_ovf(push_drop), .set_rde(rd_fault),
    .wr_en(csr_wr),
    .clr_ovf_bit(csr_wdata[BIT_OVF]), .clr_rde_bit(csr_wdata[BIT_RDE]),
    .ovf_flag(ovf_flag), .rde_flag(rde_flag)
  );

  assign fb_busy = eng_valid || fb_active;
  assign rp_busy = eng_valid || raster_active;
  assign csr_rdata = cq_pack(cq_free(DEPTH, int'(used)), fb_busy, rp_busy,
                             rde_flag, ovf_flag);

  assert_busy_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> (csr_rdata[BIT_FBB] && csr_rdata[BIT_RPB]));
  assert_zero_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[23:12] == '0) && (csr_rdata[29:26] == '0));
  assert_valid_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid == (csr_rdata[FREE_W-1:0] != FREE_W'(DEPTH)));
endmodule

// File: tb/test_cmd_queue_csr.sv
`timescale 1ns/1ps
module test_cmd_queue_csr;
  localparam int DEPTH = 16;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic cmd_wr = 0, csr_wr = 0, rd_fault = 0;
  logic raster_active = 0, fb_active = 0, eng_ready = 0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic eng_valid;
  logic [DW-1:0] eng_data;

  int errs = 0, checks = 0;
  bit done = 0;
  int model_q[$];

  always #2.5 clk = ~clk;

  cmd_queue_csr #(.DEPTH(DEPTH), .DATA_W(DW)) i_cmd_queue_csr (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rd_fault(rd_fault), .raster_active(raster_active), .fb_active(fb_active),
    .eng_valid(eng_valid), .eng_data(eng_data), .eng_ready(eng_ready));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int used, input bit ovf, input bit rde);
    logic [31:0] w;
    w = 32'(DEPTH - used);
    w[24] = (used != 0) || fb_active;
    w[25] = (used != 0) || raster_active;
    w[30] = rde;
    w[31] = ovf;
    return w;
  endfunction

  task automatic step();
    @(posedge clk); #1;
    cmd_wr = 0; csr_wr = 0; rd_fault = 0; csr_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit ovf = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    // R1 reset state
    chk("R1", csr_rdata, exp_word(0, 0, 0));
    chk("R1", {31'b0, eng_valid}, 0);

    // R2/R4: fill past capacity with engine stalled
    for (int i = 0; i < DEPTH + 4; i++) begin
      cmd_wr = 1; cmd_wdata = 32'(i * 7 + 1);
      if (model_q.size() < DEPTH) model_q.push_back(i * 7 + 1); else ovf = 1;
      step();
      chk(ovf ? "R4" : "R2", csr_rdata, exp_word(model_q.size(), ovf, 0));
    end
    chk("R5", {31'b0, eng_valid}, 1);

    // R6 with queue non-empty: all activity combos
    for (int c = 0; c < 4; c++) begin
      raster_active = c[0]; fb_active = c[1]; #1;
      chk("R6", csr_rdata, exp_word(DEPTH, 1, 0));
    end
    raster_active = 0; fb_active = 0;

    // R8 writing zeros leaves overflow; R9 other bits unaffected
    csr_wr = 1; csr_wdata = 32'h3FFF_FFFF; step();
    chk("R8", csr_rdata, exp_word(DEPTH, 1, 0));
    chk("R9", csr_rdata & 32'h3CFF_F000, 0);
    csr_wr = 1; csr_wdata = 32'h8000_0000; step();
    ovf = 0;
    chk("R8", csr_rdata, exp_word(DEPTH, 0, 0));

    // R4: full queue, write with simultaneous pop: write dropped, pop happens
    cmd_wr = 1; cmd_wdata = 32'hDEAD; eng_ready = 1;
    void'(model_q.pop_front()); ovf = 1;
    step(); eng_ready = 0;
    chk("R4", csr_rdata, exp_word(model_q.size(), 1, 0));
    csr_wr = 1; csr_wdata = 32'h8000_0000; step(); ovf = 0;

    // R5 drain in order, R2 free count rises
    while (model_q.size() > 0) begin
      chk("R5", eng_data, 32'(model_q[0]));
      eng_ready = 1; void'(model_q.pop_front());
      step();
      chk("R2", csr_rdata, exp_word(model_q.size(), 0, 0));
    end
    eng_ready = 0;
    chk("R5", {31'b0, eng_valid}, 0);

    // R3 push and pop in same cycle
    for (int i = 0; i < 3; i++) begin
      cmd_wr = 1; cmd_wdata = 32'(100 + i); model_q.push_back(100 + i); step();
    end
    for (int i = 0; i < 5; i++) begin
      chk("R5", eng_data, 32'(model_q[0]));
      cmd_wr = 1; cmd_wdata = 32'(200 + i); eng_ready = 1;
      void'(model_q.pop_front()); model_q.push_back(200 + i);
      step();
      chk("R3", csr_rdata, exp_word(3, 0, 0));
    end
    while (model_q.size() > 0) begin
      chk("R5", eng_data, 32'(model_q[0]));
      void'(model_q.pop_front()); step();
    end
    eng_ready = 0; step();
    chk("R2", csr_rdata, exp_word(0, 0, 0));

    // R6 empty queue: busy follows stage inputs
    for (int c = 0; c < 4; c++) begin
      raster_active = c[0]; fb_active = c[1]; #1;
      chk("R6", csr_rdata, exp_word(0, 0, 0));
    end
    raster_active = 0; fb_active = 0;

    // R7 read error sticky
    rd_fault = 1; step();
    chk("R7", csr_rdata, exp_word(0, 0, 1));
    step(); step();
    chk("R7", csr_rdata, exp_word(0, 0, 1));
    // R8 set and clear same cycle: set wins
    rd_fault = 1; csr_wr = 1; csr_wdata = 32'h4000_0000; step();
    chk("R8", csr_rdata, exp_word(0, 0, 1));
    csr_wr = 1; csr_wdata = 32'h8000_0000; step();
    chk("R8", csr_rdata, exp_word(0, 0, 1));
    csr_wr = 1; csr_wdata = 32'hC000_0000; step();
    chk("R8", csr_rdata, exp_word(0, 0, 0));
    chk("R9", csr_rdata & 32'h3CFF_F000, 0);

    finish_run();
  end
endmodule